// File: doc/BRIEF.md
# UART Interrupt Priority Resolver

This block sits beside the interrupt-enable register of a UART. It takes the raw condition flags of the serial port and qualifies each one with its enable bit. It then reports the single most urgent pending cause as a 4-bit identification code, together with one interrupt request line for the interrupt controller. Four priority levels are fixed. Line-status errors rank highest. Received data and character timeout share the second level. Transmit-holding-empty ranks third, and modem-status change ranks last.

Software services an interrupt by reading the identification code. Most conditions are cleared by the surrounding UART logic when the matching data or status register is accessed. The transmit-empty condition is the exception. Reading the identification code while it shows transmit-empty is itself the acknowledge. That source stays silent until the holding register has been refilled (the empty flag drops) and has emptied again.

Top module: `uart_irq_resolver`

## Requirements
- R1: With enable bit 2 set and the line-error flag high, the code is 0x6, whatever other sources are pending; with bit 2 clear the line-error flag is ignored.
- R2: With enable bit 0 set and the receive-available flag high (no line-status interrupt), the code is 0x4, outranking transmit-empty and modem-status.
- R3: With enable bit 0 set, FIFO mode on and the timeout flag high, the code is 0xC, unless a line-status or receive-available interrupt is pending; receive-available is reported first when both are present; with FIFO mode off the timeout flag is ignored.
- R4: Transmit-empty yields code 0x2 only when both enable bit 1 and enable bit 7 are set and no higher source is pending.
- R5: With enable bit 3 set and the modem-change flag high, the code is 0x0 only when no other enabled source is pending.
- R6: With nothing enabled and pending the code is 0x1; the interrupt line is high exactly when the code differs from 0x1.
- R7: A read strobe sampled on a clock edge while the code is 0x2 suppresses the transmit-empty source from the following cycle on, for as long as the empty flag stays high; lower sources then become visible.
- R8: Once the empty flag has been low for at least one clock edge, a later high empty flag raises the transmit-empty interrupt again.
- R9: A read strobe while the code shows anything other than 0x2 leaves the transmit-empty source untouched.
- R10: Reset clears any transmit-empty suppression, so a high empty flag is reported right after reset.
- R11: Enable bits 4, 5 and 6 have no effect on the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ierByte | input | 8 | Interrupt-enable byte |
| lineErr | input | 1 | Receiver line-status error pending |
| rxAvail | input | 1 | Received data available |
| charTimeout | input | 1 | Character timeout pending |
| txEmpty | input | 1 | Transmit holding register empty |
| modemChg | input | 1 | Modem-status change pending |
| fifoEn | input | 1 | FIFO mode enabled |
| iidRead | input | 1 | One-cycle strobe: identification code is being read |
| iid | output | 4 | Identification code of the winning source |
| irq | output | 1 | Interrupt request |

## Verification
An identification read can land in the same cycle as a higher-priority source that masks transmit-empty. In that cycle the read-acknowledge and the priority selection interact. The bench raises a line error together with transmit-empty and pulses the read strobe while 0x6 is shown. It then drops the line error and expects 0x2, so the read must not have acknowledged the hidden transmit source. The opposite case is also covered: a read while 0x2 is shown, with a modem change pending, must expose 0x0 on the next cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IID_W = 4;
  localparam int IER_W = 8;

  localparam logic [IID_W-1:0] IID_LINE    = 4'h6;
  localparam logic [IID_W-1:0] IID_RXDATA  = 4'h4;
  localparam logic [IID_W-1:0] IID_TIMEOUT = 4'hC;
  localparam logic [IID_W-1:0] IID_TXEMPTY = 4'h2;
  localparam logic [IID_W-1:0] IID_MODEM   = 4'h0;
  localparam logic [IID_W-1:0] IID_NONE    = 4'h1;

  // Strobes from control to datapath
  typedef struct packed {
    logic setTxMask;
    logic dropTxMask;
  } ctlStrobe_t;
endpackage

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl
  import uart_irq_pkg::*;
(
  input  logic       iidRead,
  input  logic       txShown,
  input  logic       txEmpty,
  output ctlStrobe_t strb
);
  always_comb begin
    strb = '0;
    // acknowledge only the source actually on display
    strb.setTxMask  = iidRead & txShown;
    // a refill (flag low) re-arms the source
    strb.dropTxMask = ~txEmpty;
  end
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int RX_BIT      = 0,
  parameter int TE_BIT      = 1,
  parameter int LS_BIT      = 2,
  parameter int MS_BIT      = 3,
  parameter int TE_GATE_BIT = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IER_W-1:0] ierByte,
  input  logic             lineErr,
  input  logic             rxAvail,
  input  logic             charTimeout,
  input  logic             txEmpty,
  input  logic             modemChg,
  input  logic             fifoEn,
  input  ctlStrobe_t       strb,
  output logic [IID_W-1:0] iid,
  output logic             irq,
  output logic             txShown
);
  logic txMask;
  logic lsHit, rdHit, toHit, teHit, msHit;

  always_ff @(posedge clk) begin
    if (!rstN)                txMask <= 1'b0;
    else if (strb.dropTxMask) txMask <= 1'b0;
    else if (strb.setTxMask)  txMask <= 1'b1;
  end

  always_comb begin
    lsHit = lineErr & ierByte[LS_BIT];
    rdHit = rxAvail & ierByte[RX_BIT];
    toHit = charTimeout & fifoEn & ierByte[RX_BIT];
    teHit = txEmpty & ~txMask & ierByte[TE_BIT] & ierByte[TE_GATE_BIT];
    msHit = modemChg & ierByte[MS_BIT];
  end

  always_comb begin
    if (lsHit)      iid = IID_LINE;
    else if (rdHit) iid = IID_RXDATA;
    else if (toHit) iid = IID_TIMEOUT;
    else if (teHit) iid = IID_TXEMPTY;
    else if (msHit) iid = IID_MODEM;
    else            iid = IID_NONE;
  end

  assign irq     = lsHit | rdHit | toHit | teHit | msHit;
  assign txShown = (iid == IID_TXEMPTY);
endmodule

// File: rtl/uart_irq_resolver.sv
module uart_irq_resolver
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] ierByte,
  input  logic       lineErr,
  input  logic       rxAvail,
  input  logic       charTimeout,
  input  logic       txEmpty,
  input  logic       modemChg,
  input  logic       fifoEn,
  input  logic       iidRead,
  output logic [3:0] iid,
  output logic       irq
);
  ctlStrobe_t strb;
  logic       txShown;

  uart_irq_ctl u_ctl (
    .iidRead(iidRead), .txShown(txShown), .txEmpty(txEmpty), .strb(strb)
  );

  uart_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .ierByte(ierByte), .lineErr(lineErr),
    .rxAvail(rxAvail), .charTimeout(charTimeout), .txEmpty(txEmpty),
    .modemChg(modemChg), .fifoEn(fifoEn), .strb(strb),
    .iid(iid), .irq(irq), .txShown(txShown)
  );
endmodule

module uart_irq_resolver_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] ierByte,
  input logic       lineErr,
  input logic       charTimeout,
  input logic       txEmpty,
  input logic       modemChg,
  input logic       fifoEn,
  input logic       iidRead,
  input logic [3:0] iid,
  input logic       irq
);
  // R6
  irq_matches_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq == (iid != 4'h1));
  // R1
  line_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineErr && ierByte[2]) |-> iid == 4'h6);
  // R4
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ierByte[7] |-> iid != 4'h2);
  // R3
  timeout_fifo_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoEn && charTimeout) |-> iid != 4'hC);
  // R7
  tx_read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (iidRead && iid == 4'h2) |=> iid != 4'h2);
  // R5
  modem_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    iid == 4'h0 |-> (modemChg && ierByte[3]));
endmodule

bind uart_irq_resolver uart_irq_resolver_chk u_chk (
  .clk(clk), .rstN(rstN), .ierByte(ierByte), .lineErr(lineErr),
  .charTimeout(charTimeout), .txEmpty(txEmpty), .modemChg(modemChg),
  .fifoEn(fifoEn), .iidRead(iidRead), .iid(iid), .irq(irq)
);

// File: tb/uart_irq_resolver_tb.sv
module uart_irq_resolver_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] ierByte = '0;
  logic       lineErr = 0, rxAvail = 0, charTimeout = 0, txEmpty = 0;
  logic       modemChg = 0, fifoEn = 0, iidRead = 0;
  logic [3:0] iid;
  logic       irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic [3:0] code;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  uart_irq_resolver u_dut (
    .clk(clk), .rstN(rstN), .ierByte(ierByte), .lineErr(lineErr),
    .rxAvail(rxAvail), .charTimeout(charTimeout), .txEmpty(txEmpty),
    .modemChg(modemChg), .fifoEn(fifoEn), .iidRead(iidRead),
    .iid(iid), .irq(irq)
  );

  // flags: {fifoEn, modemChg, txEmpty, charTimeout, rxAvail, lineErr}
  task automatic step(input logic [7:0] ier, input logic [5:0] flags,
                      input logic rd, input logic [3:0] exp, input string tag);
    @(posedge clk);
    #2;
    ierByte = ier;
    {fifoEn, modemChg, txEmpty, charTimeout, rxAvail, lineErr} = flags;
    iidRead = rd;
    expQ.push_back('{code: exp, tag: tag});
  endtask

  // monitor: compare at the falling edge, away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (iid !== e.code || irq !== (e.code != 4'h1)) begin
        fails++;
        $display("FAIL %s: iid=%h irq=%b expected iid=%h irq=%b",
                 e.tag, iid, irq, e.code, (e.code != 4'h1));
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    step(8'h00, 6'b000000, 0, 4'h1, "R6 idle after reset");
    step(8'h8F, 6'b111111, 0, 4'h6, "R1 line status wins");
    step(8'h8B, 6'b000001, 0, 4'h1, "R1 line disabled");
    step(8'h8F, 6'b111110, 0, 4'h4, "R2 rx data over timeout R3");
    step(8'h8F, 6'b011010, 0, 4'h4, "R2 rx over tx and modem");
    step(8'h8F, 6'b111100, 0, 4'hC, "R3 timeout with fifo");
    step(8'h8F, 6'b011100, 0, 4'h2, "R3 timeout ignored fifo off");
    step(8'h0F, 6'b001000, 0, 4'h1, "R4 tx needs bit 7");
    step(8'h80, 6'b001000, 0, 4'h1, "R4 tx needs bit 1");
    step(8'h82, 6'b001000, 0, 4'h2, "R4 tx both bits");
    step(8'h8F, 6'b011000, 0, 4'h2, "R5 modem below tx");
    step(8'h8F, 6'b010000, 0, 4'h0, "R5 modem alone");
    step(8'h70, 6'b111111, 0, 4'h1, "R11 bits 4-6 inert");
    step(8'h7F, 6'b011000, 0, 4'h0, "R11 bits 4-6 no tx gate");
    // R9: read while line status shown must not ack hidden tx
    step(8'h8F, 6'b001001, 1, 4'h6, "R9 read during line status");
    step(8'h8F, 6'b001000, 0, 4'h2, "R9 tx still pending");
    // R7: read-acknowledge of tx
    step(8'h8F, 6'b011000, 1, 4'h2, "R7 tx shown at read");
    step(8'h8F, 6'b011000, 0, 4'h0, "R7 tx hidden modem shows");
    step(8'h8F, 6'b001000, 0, 4'h1, "R7 tx stays hidden");
    // R8: refill then empty again
    step(8'h8F, 6'b000000, 0, 4'h1, "R8 holding refilled");
    step(8'h8F, 6'b001000, 0, 4'h2, "R8 tx rearmed");
    // R10: reset clears suppression
    step(8'h8F, 6'b001000, 1, 4'h2, "R10 ack before reset");
    step(8'h8F, 6'b001000, 0, 4'h1, "R10 hidden before reset");
    @(posedge clk);
    #2 rstN = 1'b0;
    @(posedge clk);
    #2 rstN = 1'b1;
    step(8'h8F, 6'b001000, 0, 4'h2, "R10 visible after reset");
    step(8'h00, 6'b000000, 0, 4'h1, "R6 all quiet");
    @(posedge clk);
    @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule